// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a bank of level-sensitive peripheral interrupt lines and a small group of non-maskable trap lines. It reduces them to one registered request toward the CPU. Each maskable source has an enable bit and a 3-bit priority field, and the CPU supplies its current priority level. A maskable source competes only when its level is above the CPU level. Traps always compete and always beat maskable sources. When two eligible sources have the same level, the one in the lower table slot wins.

When the CPU acknowledges the request, the block does three things in one clock. It latches the vector number of the winning source, and it latches the address of that source's vector-table entry. It also clears the source's pending flag.

When the CPU runs from the alternate code segment, every source resolves to one shared entry address instead. Software then reads the latched vector number to learn which source was taken. The number of cycles from request to `int_req` is the same for every source.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While reset is held and right after it, `int_req`, `vec_num` and `vec_addr` are all zero.
- R2: When an eligible source's line is first sampled high at a clock edge and `ack` is low, `int_req` is high after the next edge. It stays high while any eligible pending source exists and no `ack` is given.
- R3: Trap line t has vector number t. A pending trap wins over every maskable source, whatever the enables, priority fields and CPU level are.
- R4: Among pending traps, the lowest line number wins.
- R5: Maskable source i has vector number 8+i and its priority field is `irq_prio[3i+2:3i]`. It is a candidate only when it is pending, `irq_en[i]` is 1 and its field is strictly greater than `cpu_prio`. A field of 0 never makes it a candidate.
- R6: Among maskable candidates, the one with the numerically highest priority field wins.
- R7: Among maskable candidates with equal priority fields, the lowest vector number wins.
- R8: On a clock with `ack` high, a winner present and `aux_seg` low, `vec_num` takes the winner's number and `vec_addr` takes 0x000004 + 2 × number. Both values are visible after that edge.
- R9: On a clock with `ack` high, a winner present and `aux_seg` high, `vec_addr` takes 0x7FFFFA and `vec_num` still takes the winner's number.
- R10: An acknowledge clears the winner's pending flag. If that source's line is high in the acknowledge cycle, the source stays pending.
- R11: Without `ack`, or with `ack` while no source is eligible, `vec_num` and `vec_addr` keep their values.
- R12: `int_req` is low in the cycle after an `ack`. It rises again one cycle later if a source is still eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | N_TRAP | Non-maskable trap request lines, line t is vector t |
| irq_req | input | N_IRQ | Maskable request lines, line i is vector 8+i |
| irq_en | input | N_IRQ | Per-source enable |
| irq_prio | input | 3*N_IRQ | Packed priority fields, source i at bits [3i+2:3i] |
| cpu_prio | input | 3 | Current CPU priority level |
| aux_seg | input | 1 | High when the CPU executes from the alternate segment |
| ack | input | 1 | CPU acknowledge of the current request |
| int_req | output | 1 | Registered request to the CPU |
| vec_addr | output | ADDR_W | Latched vector-table entry address or shared address |
| vec_num | output | VEC_W | Latched number of the taken source |

## Verification
The first set of tests applies single requests one at a time, which checks the latency and the addresses in isolation. The next tests mix traps with maskable sources. These show whether traps come first and whether trap order is by line number. Pairs of maskable sources are then given with different priority fields and with equal fields, which separates priority-first ordering from table-order ties. Further tests use a disabled source, a zero field and a field at or below the CPU level, which checks the eligibility mask. Finally, a source is held high through its acknowledge and the segment flag is toggled, which exercises the clearing rule and the shared-vector mode.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int unsigned PRIO_W     = 3;
   localparam int unsigned TRAP_SLOTS = 8;
   typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req,
   input  logic [W-1:0] clr,
   output logic [W-1:0] pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr) | req;
   end

   // R10: a line that is high always leaves its flag set
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & $past(req)) == $past(req)));
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
   import vic_pkg::*;
#(
   parameter int unsigned N_TRAP = 7,
   parameter int unsigned N_IRQ  = 32,
   parameter int unsigned VEC_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_TRAP-1:0]        trap_pend,
   input  logic [N_IRQ-1:0]         irq_pend,
   input  logic [N_IRQ-1:0]         irq_en,
   input  logic [N_IRQ*PRIO_W-1:0]  irq_prio,
   input  prio_t                    cpu_prio,
   output logic                     win_valid,
   output logic                     win_is_trap,
   output logic [VEC_W-1:0]         win_vec,
   output prio_t                    win_prio
);
   logic [N_IRQ-1:0] elig;
   logic             t_hit, m_hit;
   logic [VEC_W-1:0] t_idx, m_idx;
   prio_t            m_best;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_elig
      assign elig[i] = irq_pend[i] & irq_en[i] &
                       (irq_prio[i*PRIO_W +: PRIO_W] > cpu_prio);
   end

   // lowest pending trap line
   always_comb begin
      t_hit = 1'b0;
      t_idx = '0;
      for (int i = N_TRAP - 1; i >= 0; i--) begin
         if (trap_pend[i]) begin
            t_hit = 1'b1;
            t_idx = VEC_W'(i);
         end
      end
   end

   // highest field, downward scan with >= so the lower index keeps ties
   always_comb begin
      m_hit  = 1'b0;
      m_idx  = '0;
      m_best = '0;
      for (int i = N_IRQ - 1; i >= 0; i--) begin
         if (elig[i] && (!m_hit || irq_prio[i*PRIO_W +: PRIO_W] >= m_best)) begin
            m_hit  = 1'b1;
            m_idx  = VEC_W'(i);
            m_best = irq_prio[i*PRIO_W +: PRIO_W];
         end
      end
   end

   assign win_valid   = t_hit | m_hit;
   assign win_is_trap = t_hit;
   assign win_vec     = t_hit ? t_idx : (VEC_W'(TRAP_SLOTS) + m_idx);
   assign win_prio    = t_hit ? '1 : m_best;

   p_trap_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|trap_pend) |-> (win_valid && win_is_trap && win_vec < VEC_W'(N_TRAP)));

   p_above_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_is_trap) |-> (win_prio > cpu_prio && win_vec >= VEC_W'(TRAP_SLOTS)));

   p_no_elig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|trap_pend) && !(|elig)) |-> !win_valid);
endmodule

// File: rtl/vic_vector.sv
module vic_vector #(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned TABLE_BASE = 'h4,
   parameter int unsigned STRIDE     = 2,
   parameter int unsigned AUX_ADDR   = 'h7FFFFA,
   parameter bit          HAS_AUX    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              aux_seg,
   input  logic [VEC_W-1:0]  vec_in,
   output logic [VEC_W-1:0]  vec_num,
   output logic [ADDR_W-1:0] vec_addr
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TABLE_BASE);
   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STRIDE);
   localparam logic [ADDR_W-1:0] AUX_A  = ADDR_W'(AUX_ADDR);

   logic [ADDR_W-1:0] entry_addr, next_addr;
   assign entry_addr = BASE_A + ADDR_W'(vec_in) * STEP_A;

   if (HAS_AUX) begin : g_aux
      assign next_addr = aux_seg ? AUX_A : entry_addr;
      p_shared_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (load && aux_seg) |=> (vec_addr == AUX_A));
   end else begin : g_flat
      assign next_addr = entry_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_num  <= '0;
         vec_addr <= '0;
      end else if (load) begin
         vec_num  <= vec_in;
         vec_addr <= next_addr;
      end
   end

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(vec_num) && $stable(vec_addr)));

   p_table_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !(HAS_AUX && aux_seg)) |=>
         (vec_addr == BASE_A + ADDR_W'(vec_num) * STEP_A));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int unsigned N_TRAP     = 7,
   parameter int unsigned N_IRQ      = 32,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned TABLE_BASE = 'h4,
   parameter int unsigned STRIDE     = 2,
   parameter int unsigned AUX_ADDR   = 'h7FFFFA,
   parameter bit          HAS_AUX    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_TRAP-1:0]       trap_req,
   input  logic [N_IRQ-1:0]        irq_req,
   input  logic [N_IRQ-1:0]        irq_en,
   input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
   input  logic [PRIO_W-1:0]       cpu_prio,
   input  logic                    aux_seg,
   input  logic                    ack,
   output logic                    int_req,
   output logic [ADDR_W-1:0]       vec_addr,
   output logic [VEC_W-1:0]        vec_num
);
   if (N_TRAP < 1 || N_TRAP > TRAP_SLOTS) begin : g_bad_trap
      $error("N_TRAP must lie in 1..TRAP_SLOTS");
   end
   if (N_IRQ < 1 || TRAP_SLOTS + N_IRQ > (1 << VEC_W)) begin : g_bad_irq
      $error("N_IRQ does not fit the vector number width");
   end
   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W out of range");
   end

   logic [N_TRAP-1:0] trap_pend, trap_clr;
   logic [N_IRQ-1:0]  irq_pend, irq_clr;
   logic              win_valid, win_is_trap, take;
   logic [VEC_W-1:0]  win_vec;
   prio_t             win_prio;

   assign take = ack & win_valid;

   for (genvar t = 0; t < N_TRAP; t++) begin : g_tclr
      assign trap_clr[t] = take & win_is_trap & (win_vec == VEC_W'(t));
   end
   for (genvar i = 0; i < N_IRQ; i++) begin : g_iclr
      assign irq_clr[i] = take & ~win_is_trap & (win_vec == VEC_W'(TRAP_SLOTS + i));
   end

   vic_pending #(.W(N_TRAP)) u_trap_pend (
      .clk(clk), .rst_n(rst_n), .req(trap_req), .clr(trap_clr), .pend(trap_pend));

   vic_pending #(.W(N_IRQ)) u_irq_pend (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(irq_clr), .pend(irq_pend));

   vic_arbiter #(.N_TRAP(N_TRAP), .N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .trap_pend(trap_pend), .irq_pend(irq_pend), .irq_en(irq_en),
      .irq_prio(irq_prio), .cpu_prio(cpu_prio),
      .win_valid(win_valid), .win_is_trap(win_is_trap),
      .win_vec(win_vec), .win_prio(win_prio));

   vic_vector #(
      .ADDR_W(ADDR_W), .VEC_W(VEC_W), .TABLE_BASE(TABLE_BASE),
      .STRIDE(STRIDE), .AUX_ADDR(AUX_ADDR), .HAS_AUX(HAS_AUX)
   ) u_vec (
      .clk(clk), .rst_n(rst_n), .load(take), .aux_seg(aux_seg),
      .vec_in(win_vec), .vec_num(vec_num), .vec_addr(vec_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_req <= 1'b0;
      else        int_req <= win_valid & ~ack;
   end

   p_ack_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !int_req);

   p_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_req) |-> ($past(|trap_pend) || $past(|irq_pend)));

   p_prio_sane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_is_trap) |-> (win_prio != '0));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 7;
   localparam int NI = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NT-1:0]     trap_req = '0;
   logic [NI-1:0]     irq_req = '0;
   logic [NI-1:0]     irq_en = '0;
   logic [NI*3-1:0]   irq_prio = '0;
   logic [2:0]        cpu_prio = '0;
   logic              aux_seg = 1'b0;
   logic              ack = 1'b0;
   logic              int_req;
   logic [23:0]       vec_addr;
   logic [7:0]        vec_num;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   vec_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
      .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio),
      .aux_seg(aux_seg), .ack(ack), .int_req(int_req),
      .vec_addr(vec_addr), .vec_num(vec_num));

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference
   bit m_tp[NT];
   bit m_ip[NI];
   int m_req = 0, m_vnum = 0, m_vaddr = 0;

   function automatic int ref_winner();
      for (int t = 0; t < NT; t++) if (m_tp[t]) return t;
      for (int lvl = 7; lvl >= 1; lvl--) begin
         if (lvl > int'(cpu_prio))
            for (int i = 0; i < NI; i++)
               if (m_ip[i] && irq_en[i] && int'(irq_prio[i*3 +: 3]) == lvl) return 8 + i;
      end
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_tp[t]) m_tp[t] = 0;
         foreach (m_ip[i]) m_ip[i] = 0;
         m_req = 0; m_vnum = 0; m_vaddr = 0;
      end else begin
         int w;
         int nreq;
         w = ref_winner();
         nreq = (w >= 0 && !ack) ? 1 : 0;
         if (ack && w >= 0) begin
            m_vnum  = w;
            m_vaddr = aux_seg ? 'h7FFFFA : 4 + 2 * w;
            if (w < 8) m_tp[w] = 0; else m_ip[w-8] = 0;
         end
         for (int t = 0; t < NT; t++) if (trap_req[t]) m_tp[t] = 1;
         for (int i = 0; i < NI; i++) if (irq_req[i]) m_ip[i] = 1;
         m_req = nreq;
      end
   end

   always @(negedge clk) begin
      checks++;
      if (int'(int_req) != m_req) begin
         errors++;
         $display("FAIL %s int_req actual=%0d expected=%0d t=%0t", cur_req, int_req, m_req, $time);
      end
      checks++;
      if (int'(vec_num) != m_vnum) begin
         errors++;
         $display("FAIL %s vec_num actual=%0d expected=%0d t=%0t", cur_req, vec_num, m_vnum, $time);
      end
      checks++;
      if (int'(vec_addr) != m_vaddr) begin
         errors++;
         $display("FAIL %s vec_addr actual=%0h expected=%0h t=%0t", cur_req, vec_addr, m_vaddr, $time);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_src(int i, int en, int p);
      irq_en[i] = en[0];
      irq_prio[i*3 +: 3] = p[2:0];
   endtask

   task automatic pulse_ack();
      ack = 1'b1; step(1); ack = 1'b0;
   endtask

   // empty every pending flag, then restore a plain configuration
   task automatic drain();
      trap_req = '0; irq_req = '0; cpu_prio = '0;
      irq_en = '1; irq_prio = '1;
      ack = 1'b1; step(NT + NI + 4); ack = 1'b0;
      irq_en = '0; irq_prio = '0; step(2);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cur_req = "R1";
      step(3);
      rst_n = 1'b1;
      step(2);

      // single request, latency and table address
      cur_req = "R2";
      set_src(3, 1, 4);
      irq_req[3] = 1'b1; step(1); irq_req[3] = 1'b0;
      step(3);
      cur_req = "R8"; pulse_ack(); step(2);
      cur_req = "R11"; step(3);
      cur_req = "R11"; pulse_ack(); step(2);
      drain();

      // trap beats maskable
      cur_req = "R3";
      set_src(0, 1, 7);
      irq_req[0] = 1'b1; trap_req[2] = 1'b1; step(1);
      irq_req[0] = 1'b0; trap_req[2] = 1'b0; step(2);
      pulse_ack(); step(2);
      drain();

      // trap order
      cur_req = "R4";
      trap_req[5] = 1'b1; trap_req[1] = 1'b1; step(1); trap_req = '0; step(2);
      pulse_ack(); step(1); pulse_ack(); step(2);
      drain();

      // eligibility mask
      cur_req = "R5";
      cpu_prio = 3'd3;
      set_src(6, 0, 6); set_src(7, 1, 0); set_src(8, 1, 3); set_src(9, 1, 2);
      irq_req[9:6] = 4'hF; step(1); irq_req = '0; step(4);
      pulse_ack(); step(2);
      set_src(8, 1, 4); step(3);
      pulse_ack(); step(2);
      drain();

      // priority first
      cur_req = "R6";
      set_src(10, 1, 2); set_src(20, 1, 6); set_src(25, 1, 5);
      irq_req[10] = 1'b1; irq_req[20] = 1'b1; irq_req[25] = 1'b1; step(1);
      irq_req = '0; step(2);
      pulse_ack(); step(1); pulse_ack(); step(1); pulse_ack(); step(2);
      drain();

      // tie on table order
      cur_req = "R7";
      set_src(9, 1, 5); set_src(4, 1, 5); set_src(31, 1, 5);
      irq_req[31] = 1'b1; irq_req[9] = 1'b1; irq_req[4] = 1'b1; step(1);
      irq_req = '0; step(2);
      pulse_ack(); step(1); pulse_ack(); step(2);
      drain();

      // shared vector in alternate segment
      cur_req = "R9";
      set_src(12, 1, 3);
      irq_req[12] = 1'b1; trap_req[6] = 1'b1; step(1);
      irq_req = '0; trap_req = '0; step(2);
      aux_seg = 1'b1; pulse_ack(); step(1);
      aux_seg = 1'b0; pulse_ack(); step(2);
      drain();

      // line held through acknowledge keeps source pending
      cur_req = "R10";
      set_src(5, 1, 2);
      irq_req[5] = 1'b1; step(3);
      pulse_ack(); step(3);
      irq_req[5] = 1'b0; pulse_ack(); step(3);
      drain();

      // drop and re-raise after acknowledge
      cur_req = "R12";
      set_src(1, 1, 1); set_src(2, 1, 1);
      irq_req[1] = 1'b1; irq_req[2] = 1'b1; step(1); irq_req = '0; step(2);
      pulse_ack(); step(1); pulse_ack(); step(3);
      drain();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule